// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block turns a stream of parallel signed audio words into a three-wire serial audio link on which it is the clock master. It produces the bit clock, the word/frame select line and the serial data line. A single shift path serves five framing conventions. These are the classic two-channel stereo format, left-justified, right-justified, and two PCM variants: one with a single-period sync pulse and one with a long sync. Each convention has its own select polarity, data offset and launch edge.

Samples arrive on a valid/ready handshake, one sample for each word slot. The word size, slot width, words per frame, bit-clock divider, framing code and option bits are held steady while the block runs. They are changed only while reset is asserted. If no sample is offered when a word slot begins, the block sends silence in that slot, keeps the framing running and raises a one-cycle underrun pulse.

Top module: `audio_serial_tx`

## Requirements
- R1: With `fmtCfg[2:0]` = 0 (stereo standard), `ws` is low for the first (left) word of a frame and high for the second (right) word. `ws` takes the next word's level during the last bit period of the current slot, so the MSB goes out one bit period after each `ws` change.
- R2: With framing codes 0, 3 and 4, a frame always holds exactly two words, whatever `wordsPerFrame` says.
- R3: With code 3 (left-justified), `ws` is high for the whole left slot and low for the whole right slot. The MSB goes out in the first bit period of the slot.
- R4: With code 4 (right-justified), the LSB (for MSB-first order) goes out in the last bit period of the slot. The leading `slotWidth - wordSize` bit periods carry zero. `ws` is high for the left slot.
- R5: With code 1 (PCM short sync), a frame is `wordsPerFrame` words sent back to back. `ws` is high only during the last bit period of the frame's last word, so each frame's first word begins right after the pulse falls.
- R6: With code 2 (PCM long sync), `ws` is high during the first `slotWidth/2` (rounded down) bit periods of the frame's first word and low everywhere else.
- R7: For codes 0, 3 and 4, `sd` and `ws` change only on falling edges of the non-inverted bit clock, because the receiver samples on rising edges. For codes 1 and 2 they change only on rising edges, because the receiver samples on falling edges.
- R8: `fmtCfg[3]` = 1 sends each word LSB first. `fmtCfg[3]` = 0 sends it MSB first.
- R9: `fmtCfg[4]` = 1 inverts `sck`, including its level while held in reset. `fmtCfg[5]` = 1 inverts `ws`.
- R10: With `gateClk` = 1, `sck` toggles only during bit periods that carry word data. Otherwise it rests at its idle level, which is low before inversion. With `gateClk` = 0 it runs continuously.
- R11: If `sampleValid` is low in the cycle `sampleReady` is high, `underrun` is high for exactly one cycle, the next. That word is sent as all zeros and the `ws` framing is unchanged.
- R12: Bit periods of a slot outside the word carry zero. Bits of `sampleData` at or above `wordSize` have no effect on `sd`.
- R13: One bit period lasts `2*(clkDiv+1)` clock cycles. `sampleReady` is a one-cycle pulse at the start of every word slot, and each handshake consumes one sample. While in reset, `sd`, `sampleReady` and `underrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleData | input | DATA_W | Signed sample, right-aligned in the low `wordSize` bits |
| sampleValid | input | 1 | Sample offered |
| sampleReady | output | 1 | Sample taken this cycle (start of a word slot) |
| wordSize | input | SIZE_W | Data bits per word, 1 to DATA_W |
| slotWidth | input | SIZE_W | Bit periods per word slot, at least 2 and at least `wordSize` |
| wordsPerFrame | input | WORDS_W | Words per frame for the PCM framings, at least 1 |
| clkDiv | input | DIV_W | Half bit period length minus one, in clock cycles |
| fmtCfg | input | 6 | [2:0] framing code, [3] LSB first, [4] invert bit clock, [5] invert select |
| gateClk | input | 1 | Stop the bit clock outside data bit periods |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Word / frame select |
| sd | output | 1 | Serial data |
| underrun | output | 1 | One-cycle pulse: a word slot started with no sample |

## Verification
The properties assume that every configuration input stays constant between reset releases, that `wordSize` does not exceed `slotWidth` or DATA_W, and that `slotWidth` is at least 2. Under those conditions a ready pulse can never be followed directly by another ready pulse, and launch-edge stability can be judged from `sck` alone. The stimulus writes configuration only while `rst_n` is low and picks every slot and word size inside those limits. Samples are offered from a counter-indexed pattern whose upper bits are deliberately non-zero, which exercises the masking rule. The bench recovers the serial stream by sampling `ws` and `sd` on the receiver's own edge and compares it against framing rules written from the requirements.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;

  typedef enum logic [2:0] {
    FRM_STEREO  = 3'd0,
    FRM_PCM_PLS = 3'd1,
    FRM_PCM_LNG = 3'd2,
    FRM_LEFT    = 3'd3,
    FRM_RIGHT   = 3'd4
  } framing_e;

  // Strobes from the slot control to the datapath.
  typedef struct packed {
    logic tick;     // slot boundary: outputs advance at this edge
    logic load;     // the coming slot starts a new word
    logic emit;     // the coming slot carries a word bit
    logic wsNext;   // select level for the coming slot (already polarity-adjusted)
    logic sckBase;  // bit clock before inversion and gating
  } slot_strobe_t;

endpackage

// File: rtl/audio_tx_clkgen.sv
module audio_tx_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clkDiv,
  output logic             phase,
  output logic             tick
);

  logic [DIV_W-1:0] halfCnt;
  logic             halfEnd;

  assign halfEnd = (halfCnt == clkDiv);
  assign tick    = halfEnd & phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halfCnt <= '0;
      phase   <= 1'b0;
    end else if (halfEnd) begin
      halfCnt <= '0;
      phase   <= ~phase;
    end else begin
      halfCnt <= halfCnt + 1'b1;
    end
  end

endmodule

// File: rtl/audio_tx_ctrl.sv
module audio_tx_ctrl
  import audio_tx_pkg::*;
#(
  parameter int SIZE_W  = 6,
  parameter int WORDS_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               phase,
  input  logic [SIZE_W-1:0]  wordSize,
  input  logic [SIZE_W-1:0]  slotWidth,
  input  logic [WORDS_W-1:0] wordsPerFrame,
  input  logic [2:0]         fmtSel,
  input  logic               invWs,
  output slot_strobe_t       strobe
);

  framing_e           framing;
  logic               twoWordFrame;
  logic               pcmTiming;
  logic [WORDS_W-1:0] wordsEff;
  logic [SIZE_W-1:0]  bitCnt, nextBit, lastBit;
  logic [WORDS_W-1:0] wordCnt, nextWord, lastWord;
  logic               primed;
  logic               bitLast;
  logic               dataNext;
  logic               wsRaw;

  // Codes 5..7 fall back to the stereo standard.
  assign framing = (fmtSel > 3'd4) ? FRM_STEREO : framing_e'(fmtSel);

  assign twoWordFrame = (framing == FRM_STEREO) || (framing == FRM_LEFT) ||
                        (framing == FRM_RIGHT);
  assign pcmTiming    = (framing == FRM_PCM_PLS) || (framing == FRM_PCM_LNG);
  assign wordsEff     = twoWordFrame ? WORDS_W'(2) : wordsPerFrame;
  assign lastBit      = slotWidth - 1'b1;
  assign lastWord     = wordsEff - 1'b1;
  assign bitLast      = (bitCnt == lastBit);

  // Position of the slot that the next tick opens.
  always_comb begin
    if (!primed) begin
      nextBit  = '0;
      nextWord = '0;
    end else if (bitLast) begin
      nextBit  = '0;
      nextWord = (wordCnt == lastWord) ? '0 : wordCnt + 1'b1;
    end else begin
      nextBit  = bitCnt + 1'b1;
      nextWord = wordCnt;
    end
  end

  // Which bit periods of a slot carry word data.
  always_comb begin
    if (framing == FRM_RIGHT) dataNext = (nextBit >= (slotWidth - wordSize));
    else                      dataNext = (nextBit < wordSize);
  end

  // Select level per framing convention.
  always_comb begin
    unique case (framing)
      FRM_PCM_PLS: wsRaw = (nextWord == lastWord) && (nextBit == lastBit);
      FRM_PCM_LNG: wsRaw = (nextWord == '0) && (nextBit < (slotWidth >> 1));
      FRM_LEFT,
      FRM_RIGHT:   wsRaw = (nextWord == '0);
      default:     wsRaw = (nextBit == lastBit) ? (nextWord == '0) : (nextWord != '0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed  <= 1'b0;
      bitCnt  <= '0;
      wordCnt <= '0;
    end else if (tick) begin
      primed  <= 1'b1;
      bitCnt  <= nextBit;
      wordCnt <= nextWord;
    end
  end

  assign strobe.tick    = tick;
  assign strobe.load    = tick && (nextBit == '0);
  assign strobe.emit    = dataNext;
  assign strobe.wsNext  = wsRaw ^ invWs;
  // Slots open with the clock low for rising-edge receivers and high for PCM.
  assign strobe.sckBase = phase ^ pcmTiming;

endmodule

// File: rtl/audio_tx_dp.sv
module audio_tx_dp
  import audio_tx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SIZE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_strobe_t      strobe,
  input  logic [DATA_W-1:0] sampleData,
  input  logic              sampleValid,
  input  logic [SIZE_W-1:0] wordSize,
  input  logic              lsbFirst,
  input  logic              invSck,
  input  logic              gateSck,
  output logic              sck,
  output logic              ws,
  output logic              sd,
  output logic              underrun
);

  logic [DATA_W-1:0] wordMask;
  logic [DATA_W-1:0] masked;
  logic [DATA_W-1:0] aligned;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] src;
  logic [DATA_W-1:0] shifted;
  logic              outBit;
  logic              activeSlot;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) wordMask[i] = (i < int'(wordSize));
  end

  assign masked  = sampleData & wordMask;
  assign aligned = lsbFirst ? masked : (masked << (DATA_W - int'(wordSize)));
  assign src     = strobe.load ? (sampleValid ? aligned : '0) : shiftReg;
  assign outBit  = lsbFirst ? src[0] : src[DATA_W-1];
  assign shifted = lsbFirst ? (src >> 1) : (src << 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shiftReg   <= '0;
      sd         <= 1'b0;
      ws         <= 1'b0;
      activeSlot <= 1'b0;
      underrun   <= 1'b0;
    end else begin
      underrun <= strobe.load & ~sampleValid;
      if (strobe.tick) begin
        sd         <= strobe.emit & outBit;
        shiftReg   <= strobe.emit ? shifted : src;
        ws         <= strobe.wsNext;
        activeSlot <= strobe.emit;
      end
    end
  end

  assign sck = (gateSck && !activeSlot) ? invSck : (strobe.sckBase ^ invSck);

endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
  import audio_tx_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SIZE_W  = 6,
  parameter int WORDS_W = 4,
  parameter int DIV_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DATA_W-1:0]  sampleData,
  input  logic               sampleValid,
  output logic               sampleReady,
  input  logic [SIZE_W-1:0]  wordSize,
  input  logic [SIZE_W-1:0]  slotWidth,
  input  logic [WORDS_W-1:0] wordsPerFrame,
  input  logic [DIV_W-1:0]   clkDiv,
  input  logic [5:0]         fmtCfg,
  input  logic               gateClk,
  output logic               sck,
  output logic               ws,
  output logic               sd,
  output logic               underrun
);

  logic         phase;
  logic         tick;
  slot_strobe_t strobe;

  audio_tx_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .clkDiv(clkDiv), .phase(phase), .tick(tick)
  );

  audio_tx_ctrl #(.SIZE_W(SIZE_W), .WORDS_W(WORDS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .phase(phase),
    .wordSize(wordSize), .slotWidth(slotWidth), .wordsPerFrame(wordsPerFrame),
    .fmtSel(fmtCfg[2:0]), .invWs(fmtCfg[5]), .strobe(strobe)
  );

  audio_tx_dp #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .sampleData(sampleData), .sampleValid(sampleValid), .wordSize(wordSize),
    .lsbFirst(fmtCfg[3]), .invSck(fmtCfg[4]), .gateSck(gateClk),
    .sck(sck), .ws(ws), .sd(sd), .underrun(underrun)
  );

  assign sampleReady = strobe.load;

endmodule

// File: rtl/audio_tx_checker.sv
module audio_tx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sampleReady,
  input logic       sampleValid,
  input logic       underrun,
  input logic       sck,
  input logic       ws,
  input logic       sd,
  input logic [5:0] fmtCfg
);

  logic sckN;
  logic pcmFmt;

  assign sckN   = sck ^ fmtCfg[4];
  assign pcmFmt = (fmtCfg[2:0] == 3'd1) || (fmtCfg[2:0] == 3'd2);

  p_ready_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
    sampleReady |=> !sampleReady);

  p_underrun_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);

  p_underrun_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleReady && !sampleValid) |=> underrun);

  p_underrun_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> !sd);

  p_launch_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pcmFmt && $rose(sckN)) |-> ($stable(sd) && $stable(ws)));

  p_launch_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pcmFmt && $fell(sckN)) |-> ($stable(sd) && $stable(ws)));

endmodule

bind audio_serial_tx audio_tx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sampleReady(sampleReady), .sampleValid(sampleValid),
  .underrun(underrun), .sck(sck), .ws(ws), .sd(sd), .fmtCfg(fmtCfg)
);

// File: tb/sim_audio_serial_tx.sv
`timescale 1ns/1ps
module sim_audio_serial_tx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] sampleData = '0;
  logic        sampleValid = 1'b0;
  logic        sampleReady;
  logic [5:0]  wordSize = 6'd16;
  logic [5:0]  slotWidth = 6'd16;
  logic [3:0]  wordsPerFrame = 4'd2;
  logic [7:0]  clkDiv = 8'd0;
  logic [5:0]  fmtCfg = 6'd0;
  logic        gateClk = 1'b0;
  logic        sck, ws, sd, underrun;

  int checks = 0;
  int errors = 0;

  localparam int CAP = 1024;
  logic capWs [CAP];
  logic capSd [CAP];
  int   capCyc [CAP];
  int   nCap = 0;
  int   cyc = 0;
  int   udCount = 0, udRun = 0, readyCount = 0, viol = 0;
  int   idx = 0;
  bit   pending = 0;
  logic prevSck = 0, prevSd = 0, prevWs = 0, prevUd = 0;

  always #2.5 clk = ~clk;

  audio_serial_tx u0 (
    .clk(clk), .rst_n(rst_n), .sampleData(sampleData), .sampleValid(sampleValid),
    .sampleReady(sampleReady), .wordSize(wordSize), .slotWidth(slotWidth),
    .wordsPerFrame(wordsPerFrame), .clkDiv(clkDiv), .fmtCfg(fmtCfg),
    .gateClk(gateClk), .sck(sck), .ws(ws), .sd(sd), .underrun(underrun)
  );

  function automatic logic [31:0] poolWord(int g);
    return 32'hC0DE_5A3C ^ (32'(g) * 32'h9E37_79B1);
  endfunction

  function automatic bit isPcm();
    return (fmtCfg[2:0] == 3'd1) || (fmtCfg[2:0] == 3'd2);
  endfunction

  // Receiver model, sample feeder and edge bookkeeping, all at the falling clk edge.
  initial begin
    forever begin
      logic sckN;
      bit   edgeS, edgeL;
      @(negedge clk);
      cyc++;
      sckN = sck ^ fmtCfg[4];
      if (!rst_n) begin
        nCap = 0; udCount = 0; udRun = 0; readyCount = 0; viol = 0;
        idx = 0; pending = 0;
        sampleData = poolWord(0);
      end else begin
        edgeS = isPcm() ? (prevSck && !sckN) : (!prevSck && sckN);
        edgeL = isPcm() ? (!prevSck && sckN) : (prevSck && !sckN);
        if (edgeS && nCap < CAP) begin
          capWs[nCap]  = ws ^ fmtCfg[5];
          capSd[nCap]  = sd;
          capCyc[nCap] = cyc;
          nCap++;
        end
        if (!gateClk && ((sd != prevSd) || (ws != prevWs)) && !edgeL) viol++;
        if (underrun) udCount++;
        if (underrun && prevUd) udRun++;
        if (sampleReady) readyCount++;
        if (pending) idx++;
        sampleData = poolWord(idx);
        pending = sampleReady && sampleValid;
      end
      prevSck = sckN; prevSd = sd; prevWs = ws; prevUd = underrun;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runCase(input logic [5:0] fmt, input logic gate, input int wsz,
                         input int slw, input int wpf, input int div, input bit feed,
                         input int ncyc);
    @(negedge clk); #1;
    rst_n = 1'b0;
    fmtCfg = fmt; gateClk = gate; wordSize = 6'(wsz); slotWidth = 6'(slw);
    wordsPerFrame = 4'(wpf); clkDiv = 8'(div); sampleValid = feed;
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (ncyc) @(negedge clk);
  endtask

  function automatic bit expWs(int f, int b, int w, int slw, int words);
    case (f)
      1: return (w == words - 1) && (b == slw - 1);
      2: return (w == 0) && (b < slw / 2);
      3, 4: return (w == 0);
      default: return (b == slw - 1) ? (w == 0) : (w != 0);
    endcase
  endfunction

  // Compare the captured stream against the framing rules.
  task automatic checkStream(input string tag, input bit feed);
    int f     = int'(fmtCfg[2:0]);
    int wsz   = int'(wordSize);
    int slw   = int'(slotWidth);
    int words = (f == 1 || f == 2) ? int'(wordsPerFrame) : 2;
    int start = gateClk ? 0 : 1;
    int badWs = 0, badSd = 0, firstWs = -1, firstSd = -1;
    check(nCap > 40, {tag, " captured length"}, nCap, 41);
    for (int i = start; i < nCap; i++) begin
      int g, b, w, k;
      bit dataSlot, eWs, eSd;
      logic [31:0] word;
      if (gateClk) begin
        g = i / wsz; k = i % wsz;
        b = (f == 4) ? (slw - wsz + k) : k;
      end else begin
        g = (i - 1) / slw; b = (i - 1) % slw;
        k = (f == 4) ? (b - (slw - wsz)) : b;
      end
      w = g % words;
      dataSlot = (f == 4) ? (b >= slw - wsz) : (b < wsz);
      word = feed ? poolWord(g) : 32'd0;
      eWs = expWs(f, b, w, slw, words);
      eSd = dataSlot ? (fmtCfg[3] ? word[k] : word[wsz - 1 - k]) : 1'b0;
      if (capWs[i] !== eWs) begin badWs++; if (firstWs < 0) firstWs = i; end
      if (capSd[i] !== eSd) begin badSd++; if (firstSd < 0) firstSd = i; end
    end
    check(badWs == 0, {tag, " ws stream mismatches (first index in actual)"}, firstWs, -1);
    check(badSd == 0, {tag, " sd stream mismatches (first index in actual)"}, firstSd, -1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; fmtCfg = 6'd0; gateClk = 0; sampleValid = 1;
    repeat (3) @(negedge clk);
    check(sd == 0, "R13 sd low in reset", sd, 0);
    check(sampleReady == 0, "R13 sampleReady low in reset", sampleReady, 0);
    check(underrun == 0, "R13 underrun low in reset", underrun, 0);
    check(sck == 0, "R9 non-inverted sck low in reset", sck, 0);
  endtask

  task automatic t_stereo();
    runCase(6'd0, 0, 16, 16, 5, 0, 1, 600);
    checkStream("R1 R2 stereo, wordsPerFrame=5 ignored", 1);
    check(viol == 0, "R7 launch edge, rising-sample framing", viol, 0);
  endtask

  task automatic t_left();
    runCase(6'd3, 0, 12, 16, 1, 0, 1, 600);
    checkStream("R3 R12 left-justified 12 in 16", 1);
  endtask

  task automatic t_right();
    runCase(6'd4, 0, 12, 16, 1, 0, 1, 600);
    checkStream("R4 R12 right-justified 12 in 16", 1);
  endtask

  task automatic t_pcmShort();
    runCase(6'd1, 0, 8, 8, 3, 0, 1, 600);
    checkStream("R5 PCM short sync, 3 words", 1);
    check(viol == 0, "R7 launch edge, PCM short", viol, 0);
  endtask

  task automatic t_pcmLong();
    runCase(6'd2, 0, 16, 16, 2, 0, 1, 600);
    checkStream("R6 PCM long sync, 2 words", 1);
    check(viol == 0, "R7 launch edge, PCM long", viol, 0);
  endtask

  task automatic t_lsbFirst();
    runCase(6'd3 | 6'd8, 0, 10, 12, 1, 0, 1, 600);
    checkStream("R8 LSB first, left-justified", 1);
  endtask

  task automatic t_invert();
    @(negedge clk); #1;
    rst_n = 1'b0; fmtCfg = 6'd0 | 6'd16 | 6'd32;
    repeat (3) @(negedge clk);
    check(sck == 1, "R9 inverted sck high in reset", sck, 1);
    runCase(6'd0 | 6'd16 | 6'd32, 0, 16, 16, 2, 0, 1, 600);
    checkStream("R9 inverted sck and ws", 1);
  endtask

  task automatic t_gate();
    runCase(6'd3, 1, 8, 12, 1, 0, 1, 600);
    checkStream("R10 gated clock: only data bits clocked", 1);
    // 300 bit periods, 8 of every 12 clocked: about 200 sampling edges
    check(nCap >= 190 && nCap <= 202, "R10 gated sampling-edge count", nCap, 200);
  endtask

  task automatic t_underrun();
    runCase(6'd0, 0, 16, 16, 2, 0, 0, 600);
    checkStream("R11 underrun sends zeros, framing kept", 0);
    check(udCount == readyCount, "R11 one underrun per empty slot", udCount, readyCount);
    check(udCount > 0, "R11 underrun observed", udCount, 1);
    check(udRun == 0, "R11 underrun lasts one cycle", udRun, 0);
  endtask

  task automatic t_divider();
    int bad = 0;
    runCase(6'd3, 0, 8, 8, 1, 2, 1, 900);
    checkStream("R13 stream with clkDiv=2", 1);
    for (int i = 2; i < nCap; i++) if (capCyc[i] - capCyc[i-1] != 6) bad++;
    check(bad == 0, "R13 bit period 6 cycles at clkDiv=2", bad, 0);
    // 900 cycles / (6*8) per word: 18 or 19 words
    check(readyCount >= 18 && readyCount <= 19, "R13 one sample per word", readyCount, 18);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_stereo();
    t_left();
    t_right();
    t_pcmShort();
    t_pcmLong();
    t_lsbFirst();
    t_invert();
    t_gate();
    t_underrun();
    t_divider();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule